// File: doc/BRIEF.md
# Multimode Down-Counting Output Timer Channel

One channel of a multifunction timer array. A 16-bit down-counter is loaded from a reload register and decremented on each cycle where the shared count-clock strobe is high. Each time the counter passes from zero back to its reload value the channel flips its output pin and emits a one-cycle underflow event, which neighbouring units such as a DMA channel or an A-D converter can use as a trigger. A one-cycle interrupt request is emitted alongside it.

A two-bit mode field picks one of three output shapes. Single-shot flips the pin at start and again at the underflow, then stops. Delayed single-shot lets a first countdown pass with no pin change, flips at the first underflow, reloads, and flips again at the second underflow before stopping. Continuous reloads on every underflow and flips the pin each time, indefinitely. While counting, software can write a signed correction that is added to the live count in the same cycle, so a period can be stretched or shortened without halting the channel.

Top module: `outtmr_channel`

## Requirements
- R1: After reset the pin is low, the count and the reload register are zero, the underflow and interrupt outputs are low and the channel is stopped.
- R2: The mode field encodes 2'b00 single-shot, 2'b01 delayed single-shot, 2'b10 continuous; with 2'b11 a start pulse is ignored and count and pin stay unchanged.
- R3: A start pulse while stopped loads the count from the reload register at the next clock edge and starts the channel; a start pulse while running is ignored.
- R4: While running, each edge with the count strobe high lowers the count by one; with the strobe low the count holds.
- R5: On a strobed edge where the count is zero, the count takes the reload value, the pin flips, and the underflow and interrupt outputs are high for exactly the following cycle.
- R6: Single-shot: the pin flips on the start edge and on the underflow, after which the channel stops holding the reload value.
- R7: Delayed single-shot: the start edge leaves the pin alone; the first underflow flips the pin and reloads the count; the second underflow flips the pin again and stops the channel.
- R8: Continuous: the start edge leaves the pin alone; the channel keeps reloading and flipping the pin at every underflow until reset.
- R9: A correction write while running adds the signed two's-complement value, modulo 2^16, to whatever count that edge would otherwise produce (decremented value or reload value); a correction while stopped, or on the start edge, is ignored.
- R10: A reload write takes effect at the next edge; a start or an underflow uses the reload register value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count strobe taken from the shared clock bus |
| start_evt | input | 1 | Start event taken from the shared input event bus |
| mode_i | input | 2 | Output mode select (encoding in R2) |
| rld_we | input | 1 | Reload register write strobe |
| rld_val | input | 16 | Reload value |
| corr_we | input | 1 | Correction write strobe |
| corr_val | input | 16 | Signed correction amount |
| count_o | output | 16 | Live count value |
| out_pin | output | 1 | Toggle-style output pin |
| udf_evt | output | 1 | Underflow event pulse for the output event bus |
| irq | output | 1 | Interrupt request pulse |

## Verification
The properties assume the mode field is only changed while the channel is stopped, and that a correction is never large enough to be confused with a plain decrement, so they compare the count only on cycles without a correction write. The stimulus sets the mode and reload before each start pulse, resets between scenarios, and places each correction write on a chosen edge — one of them deliberately on the underflow edge — so every expected underflow cycle follows from the reload and correction arithmetic alone.

// File: rtl/outtmr_pkg.sv
package outtmr_pkg;

    // Mode codes as seen on the mode input
    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'b00,
        MODE_DELAYED = 2'b01,
        MODE_FREE    = 2'b10,
        MODE_NONE    = 2'b11
    } tmr_mode_e;

    // Sequencer phase; PH_IDLE must stay zero (reset value)
    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_LEAD  = 2'b01,
        PH_FINAL = 2'b10,
        PH_LOOP  = 2'b11
    } phase_e;

endpackage

// File: rtl/outtmr_seq.sv
module outtmr_seq
    import outtmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic       zero_i,
    output logic       load_o,
    output logic       wrap_o,
    output logic       run_o,
    output logic       out_o,
    output logic       udf_o,
    output logic       irq_o
);

    typedef struct packed {
        phase_e phase;
        logic   pin;
        logic   udf;
        logic   irq;
    } seq_t;

    seq_t      st_d;
    seq_t      st_q;
    tmr_mode_e mode;

    always_comb begin
        mode     = tmr_mode_e'(mode_i);
        st_d     = st_q;
        st_d.udf = 1'b0;
        st_d.irq = 1'b0;
        load_o   = (st_q.phase == PH_IDLE) && start_i && (mode != MODE_NONE);
        wrap_o   = (st_q.phase != PH_IDLE) && tick_i && zero_i;

        if (load_o) begin
            case (mode)
                MODE_ONESHOT: begin
                    st_d.phase = PH_FINAL;
                    st_d.pin   = ~st_q.pin;
                end
                MODE_DELAYED: st_d.phase = PH_LEAD;
                default:      st_d.phase = PH_LOOP;
            endcase
        end else if (wrap_o) begin
            st_d.pin = ~st_q.pin;
            st_d.udf = 1'b1;
            st_d.irq = 1'b1;
            case (st_q.phase)
                PH_LEAD:  st_d.phase = PH_FINAL;
                PH_FINAL: st_d.phase = PH_IDLE;
                default:  st_d.phase = st_q.phase;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o = (st_q.phase != PH_IDLE);
    assign out_o = st_q.pin;
    assign udf_o = st_q.udf;
    assign irq_o = st_q.irq;

endmodule

// File: rtl/outtmr_count.sv
module outtmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             load_i,
    input  logic             wrap_i,
    input  logic             rld_we_i,
    input  logic [CNT_W-1:0] rld_val_i,
    input  logic             corr_we_i,
    input  logic [CNT_W-1:0] corr_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic             zero_o
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
    } cnt_t;

    cnt_t             r_d;
    cnt_t             r_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] adj;

    always_comb begin
        r_d = r_q;
        // value this edge would produce without any correction
        if (load_i || wrap_i) begin
            base = r_q.rld;
        end else if (run_i && tick_i) begin
            base = r_q.cnt - STEP;
        end else begin
            base = r_q.cnt;
        end
        // correction only counts while the channel is already running
        adj      = (run_i && corr_we_i) ? corr_val_i : '0;
        r_d.cnt  = base + adj;
        if (rld_we_i) begin
            r_d.rld = rld_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_o  = r_q.cnt;
    assign rld_o  = r_q.rld;
    assign zero_o = (r_q.cnt == '0);

endmodule

// File: rtl/outtmr_channel.sv
module outtmr_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             start_evt,
    input  logic [1:0]       mode_i,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_val,
    input  logic             corr_we,
    input  logic [CNT_W-1:0] corr_val,
    output logic [CNT_W-1:0] count_o,
    output logic             out_pin,
    output logic             udf_evt,
    output logic             irq
);

    logic             load_w;
    logic             wrap_w;
    logic             run_w;
    logic             zero_w;
    logic [CNT_W-1:0] reload_w;

    outtmr_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (cnt_tick),
        .start_i (start_evt),
        .mode_i  (mode_i),
        .zero_i  (zero_w),
        .load_o  (load_w),
        .wrap_o  (wrap_w),
        .run_o   (run_w),
        .out_o   (out_pin),
        .udf_o   (udf_evt),
        .irq_o   (irq)
    );

    outtmr_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (cnt_tick),
        .run_i      (run_w),
        .load_i     (load_w),
        .wrap_i     (wrap_w),
        .rld_we_i   (rld_we),
        .rld_val_i  (rld_val),
        .corr_we_i  (corr_we),
        .corr_val_i (corr_val),
        .cnt_o      (count_o),
        .rld_o      (reload_w),
        .zero_o     (zero_w)
    );

endmodule

// File: rtl/outtmr_channel_chk.sv
module outtmr_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_tick,
    input logic             start_evt,
    input logic [1:0]       mode_i,
    input logic             corr_we,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] reload_w,
    input logic             run_w,
    input logic             out_pin,
    input logic             udf_evt
);

    assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && start_evt && mode_i != 2'b11) |=> (run_w && count_o == $past(reload_w)));

    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && cnt_tick && count_o != '0 && !corr_we) |=> (count_o == $past(count_o) - CNT_W'(1)));

    assert_strobe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && !cnt_tick && !corr_we) |=> $stable(count_o));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !(start_evt && mode_i != 2'b11)) |=> ($stable(count_o) && $stable(out_pin)));

    assert_udf_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        udf_evt |-> $past(run_w && cnt_tick && count_o == '0));

    assert_udf_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        udf_evt |-> (out_pin != $past(out_pin)));

endmodule

bind outtmr_channel outtmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_tick  (cnt_tick),
    .start_evt (start_evt),
    .mode_i    (mode_i),
    .corr_we   (corr_we),
    .count_o   (count_o),
    .reload_w  (reload_w),
    .run_w     (run_w),
    .out_pin   (out_pin),
    .udf_evt   (udf_evt)
);

// File: tb/outtmr_channel_bench.sv
module outtmr_channel_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_tick = 1'b1;
    logic         start_evt = 1'b0;
    logic [1:0]   mode_i = 2'b00;
    logic         rld_we = 1'b0;
    logic [W-1:0] rld_val = '0;
    logic         corr_we = 1'b0;
    logic [W-1:0] corr_val = '0;
    logic [W-1:0] count_o;
    logic         out_pin;
    logic         udf_evt;
    logic         irq;

    always #5 clk = ~clk;

    outtmr_channel #(.CNT_W(W)) u_outtmr_channel (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .start_evt(start_evt),
        .mode_i(mode_i), .rld_we(rld_we), .rld_val(rld_val), .corr_we(corr_we),
        .corr_val(corr_val), .count_o(count_o), .out_pin(out_pin),
        .udf_evt(udf_evt), .irq(irq)
    );

    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int unsigned at;
        logic        lvl;
        int          req;
    } exp_t;

    exp_t sb[$];

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic expect_udf(int unsigned at, logic lvl, int req);
        exp_t e;
        e.at  = at;
        e.lvl = lvl;
        e.req = req;
        sb.push_back(e);
    endtask

    // monitor: pops the scoreboard on every underflow pulse
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !done) begin
            if (irq !== udf_evt) check(1'b0, "R5", "irq differs from underflow", int'(irq), int'(udf_evt));
            if (udf_evt) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5", "unexpected underflow at cycle", int'(cyc), 0);
                end else begin
                    e = sb.pop_front();
                    check(e.at == cyc, $sformatf("R%0d", e.req), "underflow cycle", int'(cyc), int'(e.at));
                    check(out_pin == e.lvl, $sformatf("R%0d", e.req), "pin after underflow", int'(out_pin), int'(e.lvl));
                end
            end
        end
    end

    task automatic drain(string req);
        check(sb.size() == 0, req, "underflows still pending", sb.size(), 0);
        sb.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start_evt = 1'b0; rld_we = 1'b0; corr_we = 1'b0; cnt_tick = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_reload(logic [W-1:0] v);
        @(negedge clk);
        rld_we = 1'b1; rld_val = v;
        @(negedge clk);
        rld_we = 1'b0;
    endtask

    task automatic fire(output int unsigned n);
        @(negedge clk);
        start_evt = 1'b1;
        n = cyc + 1;
        @(negedge clk);
        start_evt = 1'b0;
    endtask

    task automatic apply_corr(logic [W-1:0] v);
        @(negedge clk);
        corr_we = 1'b1; corr_val = v;
        @(negedge clk);
        corr_we = 1'b0;
    endtask

    task automatic wait_until(int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    int unsigned n;
    int unsigned m;

    initial begin
        // R1 reset state
        do_reset();
        @(negedge clk);
        check(count_o == 0, "R1", "count after reset", int'(count_o), 0);
        check(out_pin == 0, "R1", "pin after reset", int'(out_pin), 0);
        check(udf_evt == 0 && irq == 0, "R1", "pulses after reset", int'(udf_evt), 0);

        // R6 single-shot, reload 5
        do_reset(); mode_i = 2'b00;
        write_reload(16'd5);
        fire(n);
        check(count_o == 5, "R3", "count after start", int'(count_o), 5);
        check(out_pin == 1, "R6", "pin after single-shot start", int'(out_pin), 1);
        expect_udf(n + 6, 1'b0, 6);
        wait_until(n + 9);
        drain("R6");
        check(count_o == 5 && out_pin == 0, "R6", "stopped count", int'(count_o), 5);
        repeat (3) @(negedge clk);
        check(count_o == 5, "R6", "count held after stop", int'(count_o), 5);

        // R7 delayed single-shot with R10 reload rewrite during first countdown
        do_reset(); mode_i = 2'b01;
        write_reload(16'd3);
        fire(n);
        check(out_pin == 0, "R7", "pin after delayed start", int'(out_pin), 0);
        write_reload(16'd5);
        expect_udf(n + 4, 1'b1, 7);
        expect_udf(n + 10, 1'b0, 10);
        wait_until(n + 4);
        check(count_o == 5, "R10", "count after first reload", int'(count_o), 5);
        wait_until(n + 14);
        drain("R7");
        check(count_o == 5 && out_pin == 0, "R7", "stopped after second underflow", int'(count_o), 5);

        // R8 continuous, reload 2
        do_reset(); mode_i = 2'b10;
        write_reload(16'd2);
        fire(n);
        check(out_pin == 0, "R8", "pin after continuous start", int'(out_pin), 0);
        expect_udf(n + 3, 1'b1, 8);
        expect_udf(n + 6, 1'b0, 8);
        expect_udf(n + 9, 1'b1, 8);
        wait_until(n + 10);
        check(count_o == 1, "R8", "still counting", int'(count_o), 1);
        drain("R8");
        do_reset();
        @(negedge clk);
        check(count_o == 0 && out_pin == 0, "R1", "reset during run", int'(count_o), 0);

        // R3 restart while running is ignored
        do_reset(); mode_i = 2'b00;
        write_reload(16'd6);
        fire(n);
        repeat (1) @(negedge clk);
        fire(m);
        check(count_o == 3, "R3", "count after ignored start", int'(count_o), 3);
        check(out_pin == 1, "R3", "pin after ignored start", int'(out_pin), 1);
        expect_udf(n + 7, 1'b0, 3);
        wait_until(n + 10);
        drain("R3");

        // R9 positive correction
        do_reset(); mode_i = 2'b00;
        write_reload(16'd10);
        fire(n);
        apply_corr(16'd4);
        check(count_o == 12, "R9", "count after +4", int'(count_o), 12);
        expect_udf(n + 15, 1'b0, 9);
        wait_until(n + 18);
        drain("R9");

        // R9 negative correction
        do_reset(); mode_i = 2'b00;
        write_reload(16'd10);
        fire(n);
        apply_corr(16'hFFFD);
        check(count_o == 5, "R9", "count after -3", int'(count_o), 5);
        expect_udf(n + 8, 1'b0, 9);
        wait_until(n + 11);
        drain("R9");

        // R9 correction on the underflow edge applies to the reload value
        do_reset(); mode_i = 2'b10;
        write_reload(16'd3);
        fire(n);
        expect_udf(n + 4, 1'b1, 9);
        expect_udf(n + 10, 1'b0, 9);
        repeat (2) @(negedge clk);
        apply_corr(16'd2);
        check(count_o == 5, "R9", "reload plus correction", int'(count_o), 5);
        wait_until(n + 11);
        drain("R9");
        do_reset();

        // R4 count strobe low holds the count
        do_reset(); mode_i = 2'b00;
        write_reload(16'd5);
        fire(n);
        cnt_tick = 1'b0;
        repeat (4) @(negedge clk);
        check(count_o == 5, "R4", "count without strobe", int'(count_o), 5);
        cnt_tick = 1'b1;
        expect_udf(n + 10, 1'b0, 4);
        wait_until(n + 6);
        check(count_o == 3, "R4", "count after two strobes", int'(count_o), 3);
        wait_until(n + 12);
        drain("R4");

        // R2 reserved mode, R9 correction while stopped
        do_reset(); mode_i = 2'b11;
        write_reload(16'd7);
        fire(n);
        check(count_o == 0 && out_pin == 0, "R2", "start in reserved mode", int'(count_o), 0);
        apply_corr(16'd5);
        check(count_o == 0, "R9", "correction while stopped", int'(count_o), 0);
        repeat (8) @(negedge clk);
        check(count_o == 0 && out_pin == 0, "R2", "still stopped", int'(count_o), 0);
        drain("R2");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc == 50000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule